// File: doc/BRIEF.md
# DRAM Rank Power-Down Controller

This block manages clock-enable power-down for a set of DRAM ranks inside a memory controller. Each rank has an idle counter that restarts whenever a read targets that rank or a request for it is pending. Once the rank has been idle for its programmed number of cycles, the block drops the rank's clock-enable and issues a NOP command for that rank in the same cycle. The rank's pad drivers are then placed in high impedance, except for clock-enable (held low) and on-die termination, which this block does not touch.

The power-down flavour is chosen at entry. If any bank in the rank holds an open page, the rank goes to active power-down and keeps its open pages. If every bank is precharged, the rank goes to precharge power-down, with fast or slow exit picked by a global setting. A pending request to a sleeping rank wakes it at once: clock-enable rises together with a NOP. The rank's command-ready flag stays low for a programmable 3 to 5 cycles. Its data-ready flag stays low for the same time, or for a longer fixed time after slow exit, because the DRAM's input delay-locked loops were off during that mode.

Top module: `rank_pd_ctrl`

## Requirements
- R1: With a nonzero timeout T for a rank, after the last cycle in which a read or request touched that rank, clock-enable stays high for exactly T further cycles and is low from the cycle after.
- R2: On entry the rank's clock-enable falls and its NOP strobe is high in the same cycle; the strobe lasts one cycle.
- R3: A pending request to a powered-down rank raises its clock-enable on the next clock edge, with the NOP strobe high for that one cycle.
- R4: The rank's pad high-impedance output is high exactly while its clock-enable is low.
- R5: The mode status (2 bits) reads 0 in normal operation, 1 for active power-down (any bank open at entry), 2 for precharge fast-exit and 3 for precharge slow-exit (all banks closed, slow-exit setting high at entry); it holds steady while the rank is down.
- R6: After clock-enable rises, command-ready stays low for N cycles, where N is the exit-delay setting clamped to the range 3 to 5.
- R7: Data-ready follows command-ready after active or fast-exit power-down, but after slow-exit power-down it stays low for 16 cycles; data-ready is never high while command-ready is low.
- R8: A timeout value of zero keeps the rank in normal operation indefinitely.
- R9: While a request to a rank in normal operation is pending, or reads keep arriving more often than the timeout, the rank does not enter power-down.
- R10: After reset every rank has clock-enable high, mode 0, both ready flags high, no NOP strobe and pads driven.
- R11: Ranks are independent: one rank entering or leaving power-down does not change another rank's clock-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_hit | input | NUM_RANKS | Read targets the rank this cycle |
| req_pend | input | NUM_RANKS | A request for the rank is pending |
| bank_open | input | NUM_RANKS | At least one bank of the rank has an open page |
| slow_exit_en | input | 1 | Use slow exit for precharge power-down |
| idle_limit | input | NUM_RANKS*TMO_W | Per-rank idle timeout in cycles, 0 disables |
| exit_dly | input | DLY_W | Command delay after wake, clamped to 3..5 |
| cke | output | NUM_RANKS | Per-rank clock-enable |
| nop_stb | output | NUM_RANKS | Per-rank NOP command strobe |
| pad_hiz | output | NUM_RANKS | Per-rank pad high-impedance enable |
| cmd_rdy | output | NUM_RANKS | Commands may be issued to the rank |
| dat_rdy | output | NUM_RANKS | Data may be transferred to the rank |
| pd_mode | output | 2*NUM_RANKS | Per-rank mode status, rank r in bits 2r+1:2r |

## Verification
On every cycle the assertions hold the pairing of each clock-enable edge with a NOP strobe, the low command-ready on the wake cycle, the ordering of data-ready after command-ready, the steadiness of the mode while a rank sleeps and the blocking of entry by a pending request. The exact idle count before entry, the choice of mode from the bank and slow-exit inputs, the clamped command delay and the longer data delay after slow exit depend on cycle counts and setup, so only the directed scenarios show them. The same holds for a disabled timeout and for independence between ranks.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

    typedef enum logic [1:0] {
        PDM_NONE     = 2'b00,
        PDM_ACT      = 2'b01,
        PDM_PRE_FAST = 2'b10,
        PDM_PRE_SLOW = 2'b11
    } pd_mode_e;

    typedef struct packed {
        logic     pd;
        pd_mode_e mode;
        logic     nop;
    } rank_st_t;

endpackage

// File: rtl/rpd_idle_timer.sv
module rpd_idle_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             touch,
    input  logic [TMO_W-1:0] limit,
    output logic             expire
);

    logic [TMO_W-1:0] cnt_q, cnt_d;
    logic [TMO_W:0]   seen;
    logic             at_limit;

    always_comb begin
        seen     = {1'b0, cnt_q} + (TMO_W+1)'(1);
        at_limit = seen >= {1'b0, limit};
        expire   = run && !touch && (limit != '0) && at_limit;
        cnt_d    = cnt_q;
        if (!run || touch || limit == '0) begin
            cnt_d = '0;
        end else if (!at_limit) begin
            cnt_d = cnt_q + TMO_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R8: no expiry can come from a counter that has been held cleared
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/rpd_exit_timer.sv
module rpd_exit_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] cmd_len,
    input  logic [CW-1:0] dat_len,
    output logic          cmd_idle,
    output logic          dat_idle
);

    typedef struct packed {
        logic [CW-1:0] cmd;
        logic [CW-1:0] dat;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cmd != '0) tmr_d.cmd = tmr_q.cmd - CW'(1);
        if (tmr_q.dat != '0) tmr_d.dat = tmr_q.dat - CW'(1);
        if (load) begin
            tmr_d.cmd = cmd_len;
            tmr_d.dat = dat_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cmd_idle = (tmr_q.cmd == '0);
    assign dat_idle = (tmr_q.dat == '0);

endmodule

// File: rtl/rpd_rank_fsm.sv
module rpd_rank_fsm
    import rpd_pkg::*;
#(
    parameter int TMO_W = 16,
    parameter int CW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_hit,
    input  logic             req,
    input  logic             bank_open,
    input  logic             slow_en,
    input  logic [TMO_W-1:0] limit,
    input  logic [CW-1:0]    cmd_len,
    input  logic [CW-1:0]    slow_dat_len,
    output logic             cke,
    output logic             nop,
    output logic             pad_hiz,
    output logic             cmd_rdy,
    output logic             dat_rdy,
    output logic [1:0]       mode
);

    rank_st_t      st_q, st_d;
    logic          expire, run, wake;
    logic          cmd_idle, dat_idle;
    logic [CW-1:0] dat_len;

    assign run     = !st_q.pd && !req && cmd_idle && dat_idle;
    assign wake    = st_q.pd && req;
    assign dat_len = (st_q.mode == PDM_PRE_SLOW) ? slow_dat_len : cmd_len;

    rpd_idle_timer #(.TMO_W(TMO_W)) idle_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .touch  (rd_hit),
        .limit  (limit),
        .expire (expire)
    );

    rpd_exit_timer #(.CW(CW)) exit_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wake),
        .cmd_len  (cmd_len),
        .dat_len  (dat_len),
        .cmd_idle (cmd_idle),
        .dat_idle (dat_idle)
    );

    always_comb begin
        st_d     = st_q;
        st_d.nop = 1'b0;
        if (expire) begin
            st_d.pd  = 1'b1;
            st_d.nop = 1'b1;
            if (bank_open)    st_d.mode = PDM_ACT;
            else if (slow_en) st_d.mode = PDM_PRE_SLOW;
            else              st_d.mode = PDM_PRE_FAST;
        end else if (wake) begin
            st_d.pd   = 1'b0;
            st_d.nop  = 1'b1;
            st_d.mode = PDM_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pd: 1'b0, mode: PDM_NONE, nop: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cke     = !st_q.pd;
    assign nop     = st_q.nop;
    assign pad_hiz = st_q.pd;
    assign cmd_rdy = !st_q.pd && cmd_idle;
    assign dat_rdy = !st_q.pd && dat_idle;
    assign mode    = st_q.mode;

    // R2: every clock-enable fall carries a NOP
    a_r2_entry_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> nop);

    // R3: every clock-enable rise carries a NOP
    a_r3_exit_nop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> nop);

    // R6: no command allowed in the wake cycle
    a_r6_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> !cmd_rdy);

    // R7: data never ready ahead of commands
    a_r7_data_order: assert property (@(posedge clk) disable iff (!rst_n)
        dat_rdy |-> cmd_rdy);

    // R5: mode steady while the rank sleeps
    a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> $stable(mode));

    // R9: a pending request keeps an awake rank awake
    a_r9_req_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (req && cke) |=> cke);

endmodule

// File: rtl/rank_pd_ctrl.sv
module rank_pd_ctrl #(
    parameter int NUM_RANKS    = 2,
    parameter int TMO_W        = 16,
    parameter int DLY_W        = 3,
    parameter int XP_MIN       = 3,
    parameter int XP_MAX       = 5,
    parameter int SLOW_DAT_DLY = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_RANKS-1:0]       rd_hit,
    input  logic [NUM_RANKS-1:0]       req_pend,
    input  logic [NUM_RANKS-1:0]       bank_open,
    input  logic                       slow_exit_en,
    input  logic [NUM_RANKS*TMO_W-1:0] idle_limit,
    input  logic [DLY_W-1:0]           exit_dly,
    output logic [NUM_RANKS-1:0]       cke,
    output logic [NUM_RANKS-1:0]       nop_stb,
    output logic [NUM_RANKS-1:0]       pad_hiz,
    output logic [NUM_RANKS-1:0]       cmd_rdy,
    output logic [NUM_RANKS-1:0]       dat_rdy,
    output logic [2*NUM_RANKS-1:0]     pd_mode
);

    localparam int LEN_MAX = (SLOW_DAT_DLY > XP_MAX) ? SLOW_DAT_DLY : XP_MAX;
    localparam int CNT_W   = $clog2(LEN_MAX + 1);

    logic [CNT_W-1:0] cmd_len;
    logic [CNT_W-1:0] slow_len;

    assign slow_len = CNT_W'(SLOW_DAT_DLY);

    always_comb begin
        cmd_len = CNT_W'(exit_dly);
        if (exit_dly < DLY_W'(XP_MIN)) begin
            cmd_len = CNT_W'(XP_MIN);
        end else if (exit_dly > DLY_W'(XP_MAX)) begin
            cmd_len = CNT_W'(XP_MAX);
        end
    end

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        rpd_rank_fsm #(.TMO_W(TMO_W), .CW(CNT_W)) fsm_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .rd_hit       (rd_hit[r]),
            .req          (req_pend[r]),
            .bank_open    (bank_open[r]),
            .slow_en      (slow_exit_en),
            .limit        (idle_limit[r*TMO_W +: TMO_W]),
            .cmd_len      (cmd_len),
            .slow_dat_len (slow_len),
            .cke          (cke[r]),
            .nop          (nop_stb[r]),
            .pad_hiz      (pad_hiz[r]),
            .cmd_rdy      (cmd_rdy[r]),
            .dat_rdy      (dat_rdy[r]),
            .mode         (pd_mode[2*r +: 2])
        );
    end

    // R6: clamped command delay stays in its legal window
    a_r6_len_window: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_len >= CNT_W'(XP_MIN)) && (cmd_len <= CNT_W'(XP_MAX)));

endmodule

// File: tb/rank_pd_ctrl_tb_top.sv
`timescale 1ns/1ps
module rank_pd_ctrl_tb_top;

    localparam int NR = 2;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] rd_hit = '0;
    logic [NR-1:0] req_pend = '0;
    logic [NR-1:0] bank_open = '0;
    logic          slow_exit_en = 1'b0;
    logic [NR*TW-1:0] idle_limit = '0;
    logic [2:0]    exit_dly = 3'd4;
    logic [NR-1:0] cke, nop_stb, pad_hiz, cmd_rdy, dat_rdy;
    logic [2*NR-1:0] pd_mode;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rank_pd_ctrl #(.NUM_RANKS(NR), .TMO_W(TW)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_hit       (rd_hit),
        .req_pend     (req_pend),
        .bank_open    (bank_open),
        .slow_exit_en (slow_exit_en),
        .idle_limit   (idle_limit),
        .exit_dly     (exit_dly),
        .cke          (cke),
        .nop_stb      (nop_stb),
        .pad_hiz      (pad_hiz),
        .cmd_rdy      (cmd_rdy),
        .dat_rdy      (dat_rdy),
        .pd_mode      (pd_mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_limit(input int r, input int lim);
        idle_limit[r*TW +: TW] = TW'(lim);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 cke", int'(cke), 3);
        chk("R10 mode", int'(pd_mode), 0);
        chk("R10 cmd_rdy", int'(cmd_rdy), 3);
        chk("R10 dat_rdy", int'(dat_rdy), 3);
        chk("R10 nop", int'(nop_stb), 0);
        chk("R10 pad_hiz", int'(pad_hiz), 0);
    endtask

    task automatic t_idle_entry(input int r, input int lim, input logic open,
                                input logic slow, input int exp_mode);
        int early;
        bank_open[r] = open;
        slow_exit_en = slow;
        set_limit(r, lim);
        rd_hit[r] = 1'b1;
        @(negedge clk);
        rd_hit[r] = 1'b0;
        early = 0;
        for (int i = 1; i < lim; i++) begin
            @(negedge clk);
            if (!cke[r]) early++;
        end
        chk("R1 early drop count", early, 0);
        @(negedge clk);
        chk("R1 cke low after timeout", int'(cke[r]), 0);
        chk("R2 nop with entry", int'(nop_stb[r]), 1);
        chk("R4 pads hiz while down", int'(pad_hiz[r]), 1);
        chk("R5 mode at entry", int'(pd_mode[2*r +: 2]), exp_mode);
        chk("R6 cmd_rdy low while down", int'(cmd_rdy[r]), 0);
        @(negedge clk);
        chk("R2 nop one cycle", int'(nop_stb[r]), 0);
        chk("R5 mode held", int'(pd_mode[2*r +: 2]), exp_mode);
    endtask

    task automatic t_wake(input int r, input int exp_cmd, input int exp_dat);
        int first_cmd;
        int first_dat;
        first_cmd = -1;
        first_dat = -1;
        req_pend[r] = 1'b1;
        @(negedge clk);
        chk("R3 cke high on wake", int'(cke[r]), 1);
        chk("R3 nop on wake", int'(nop_stb[r]), 1);
        chk("R4 pads driven after wake", int'(pad_hiz[r]), 0);
        chk("R5 mode normal", int'(pd_mode[2*r +: 2]), 0);
        for (int i = 0; i < 40; i++) begin
            if (i > 0) @(negedge clk);
            if (i == 1) chk("R3 nop one cycle", int'(nop_stb[r]), 0);
            if (cmd_rdy[r] && first_cmd < 0) first_cmd = i;
            if (dat_rdy[r] && first_dat < 0) first_dat = i;
        end
        chk("R6 command delay", first_cmd, exp_cmd);
        chk("R7 data delay", first_dat, exp_dat);
        set_limit(r, 0);
        req_pend[r] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_block(input int r);
        int drops;
        drops = 0;
        set_limit(r, 4);
        req_pend[r] = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!cke[r]) drops++;
        end
        req_pend[r] = 1'b0;
        for (int i = 0; i < 18; i++) begin
            rd_hit[r] = (i % 3 == 0);
            @(negedge clk);
            if (!cke[r]) drops++;
        end
        chk("R9 no entry while busy", drops, 0);
        set_limit(r, 0);
        rd_hit[r] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_indep();
        int r0_drops;
        r0_drops = 0;
        set_limit(0, 0);
        t_idle_entry(1, 3, 1'b0, 1'b0, 2);
        chk("R11 rank0 unaffected by rank1 entry", int'(cke[0]), 1);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (!cke[0]) r0_drops++;
        end
        chk("R8 zero timeout stays up", r0_drops, 0);
        chk("R1 rank1 stays down without request", int'(cke[1]), 0);
        exit_dly = 3'd3;
        t_wake(1, 3, 3);
        chk("R11 rank0 unaffected by rank1 wake", int'(cke[0]), 1);
    endtask

    initial begin
        t_reset();
        exit_dly = 3'd4;
        t_idle_entry(0, 6, 1'b1, 1'b0, 1);
        t_wake(0, 4, 4);
        exit_dly = 3'd1;
        t_idle_entry(0, 2, 1'b0, 1'b0, 2);
        t_wake(0, 3, 3);
        exit_dly = 3'd7;
        t_idle_entry(0, 5, 1'b0, 1'b1, 3);
        t_wake(0, 5, 16);
        t_block(0);
        t_indep();
        exit_dly = 3'd5;
        t_idle_entry(0, 1, 1'b1, 1'b1, 1);
        t_wake(0, 5, 5);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule